// File: doc/BRIEF.md
# Byte ALU with Status Flags and Branch Test

This block is the arithmetic core of a small processor that holds its data in eight byte-wide registers. Each cycle the decoder presents two operand bytes and an operation code. The block returns the result byte and a write strobe for the destination register. It also keeps the four condition flags in a register of its own: zero, carry, negative and signed overflow. Byte loads pass the second operand through to the register file and do not change the flags. Every arithmetic operation rewrites all four flags at the next rising clock edge.

Subtraction uses a carry that means "no borrow". Subtract-with-borrow therefore takes away one extra only when the stored carry is clear. The compare operation sets the flags exactly as a subtraction does, but it writes no register. A separate branch test reads the stored flags and a branch code and reports at once whether the branch is taken. It therefore reflects the flags left by the instruction before it.

Top module: `alu8_flags`

## Requirements
- R1: Operation code 1 (add) drives the result (a + b) mod 256 and asserts the write strobe. After the next rising edge the carry flag holds bit 8 of a + b.
- R2: Operation code 2 (add with carry) drives (a + b + C) mod 256, where C is the stored carry, and asserts the write strobe. After the next edge the carry flag holds bit 8 of that sum.
- R3: Operation code 3 (subtract) drives (a − b) mod 256 and asserts the write strobe. After the next edge the carry flag is 1 exactly when a ≥ b as unsigned numbers, which means no borrow occurred.
- R4: Operation code 4 (subtract with borrow) drives (a − b − (1 − C)) mod 256 and asserts the write strobe. After the next edge the carry flag is 1 exactly when a ≥ b + (1 − C) as unsigned numbers.
- R5: Operation code 5 (test) keeps the write strobe low. After the next edge all four flags are set exactly as operation code 3 would set them.
- R6: After any arithmetic operation (codes 1 to 5), the zero flag is 1 exactly when the 8-bit result is 0, and the negative flag equals bit 7 of the result.
- R7: After an add-type operation, the overflow flag is 1 when a and b have the same sign and the result's sign differs from them. After a subtract-type operation, it is 1 when a and b have different signs and the result's sign differs from that of a.
- R8: Operation code 0 (load) drives b as the result and asserts the write strobe. Codes 6 to 15 keep the write strobe low. Neither code 0 nor codes 6 to 15 change any flag.
- R9: The flags change only at a rising clock edge. A synchronous reset clears all four flags to 0 and takes priority over any operation.
- R10: Branch taken is combinational from the stored flags and the branch code. Codes 0/1 test Z = 1/0, codes 2/3 test C = 1/0, codes 4/5 test V = 1/0, codes 6/7 test N = 1/0, code 8 is always taken, and codes 9 to 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the flags |
| op | input | 4 | Operation code |
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand or immediate byte |
| br_sel | input | 4 | Branch condition code |
| res | output | 8 | Result byte for the destination register |
| wr_en | output | 1 | Destination register write strobe |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag (no-borrow on subtraction) |
| flag_n | output | 1 | Stored negative flag |
| flag_v | output | 1 | Stored signed overflow flag |
| br_taken | output | 1 | Branch condition satisfied |

## Verification
The only internal state is the flag register. A wrong flag is visible on the flag ports one edge after the operation that wrote it, and the branch output shows it in the same cycle. It also spreads to the very next add-with-carry or subtract-with-borrow, whose result byte then differs by one. For this reason the chained carry operations are run with both stored carry values, at the sign and wrap corners 0x00, 0x01, 0x7F, 0x80 and 0xFF. The reference model is compared on every clock, so a flag that drifts during a load or an idle code is caught at the first edge where it changes.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W   = 8,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [3:0]     br_sel,
  output logic [W-1:0]   res,
  output logic           wr_en,
  output logic           flag_z,
  output logic           flag_c,
  output logic           flag_n,
  output logic           flag_v,
  output logic           br_taken
);

  localparam logic [OPW-1:0] OP_LD  = OPW'(0);
  localparam logic [OPW-1:0] OP_ADD = OPW'(1);
  localparam logic [OPW-1:0] OP_ADC = OPW'(2);
  localparam logic [OPW-1:0] OP_SUB = OPW'(3);
  localparam logic [OPW-1:0] OP_SBB = OPW'(4);
  localparam logic [OPW-1:0] OP_TST = OPW'(5);

  logic           is_sub, is_arith, cin, ovf;
  logic [W-1:0]   b_eff;
  logic [W:0]     sum;

  assign is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_TST);
  assign is_arith = is_sub || (op == OP_ADD) || (op == OP_ADC);
  assign b_eff    = is_sub ? ~opb : opb;
  assign cin      = (op == OP_ADC || op == OP_SBB) ? flag_c : is_sub;
  assign sum      = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign ovf      = (opa[W-1] == b_eff[W-1]) && (sum[W-1] != opa[W-1]);

  assign res   = (op == OP_LD) ? opb : (is_arith ? sum[W-1:0] : '0);
  assign wr_en = (op == OP_LD) || (is_arith && op != OP_TST);

  always_ff @(posedge clk) begin
    if (rst) begin
      {flag_z, flag_c, flag_n, flag_v} <= 4'b0000;
    end else if (is_arith) begin
      flag_z <= (sum[W-1:0] == '0);
      flag_c <= sum[W];
      flag_n <= sum[W-1];
      flag_v <= ovf;
    end
  end

  always_comb begin
    case (br_sel)
      4'd0:    br_taken = flag_z;
      4'd1:    br_taken = !flag_z;
      4'd2:    br_taken = flag_c;
      4'd3:    br_taken = !flag_c;
      4'd4:    br_taken = flag_v;
      4'd5:    br_taken = !flag_v;
      4'd6:    br_taken = flag_n;
      4'd7:    br_taken = !flag_n;
      4'd8:    br_taken = 1'b1;
      default: br_taken = 1'b0;
    endcase
  end

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> ({flag_z, flag_c, flag_n, flag_v} == 4'b0000));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !is_arith |=> $stable({flag_z, flag_c, flag_n, flag_v}));

  a_r1_add_carry: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |=> (flag_c == ((({1'b0, $past(opa)} + {1'b0, $past(opb)}) >> W) != '0)));

  a_r3_sub_no_borrow: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |=> (flag_c == ($past(opa) >= $past(opb))));

  a_r6_zero_neg: assert property (@(posedge clk) disable iff (rst)
    is_arith |=> (flag_z == ($past(res) == '0)) && (flag_n == $past(res[W-1])));

  a_r5_test_no_write: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TST) |-> !wr_en);

  a_r10_always_taken: assert property (@(posedge clk) disable iff (rst)
    (br_sel == 4'd8) |-> br_taken);

endmodule

// File: tb/test_alu8_flags.sv
module test_alu8_flags;
  logic       clk = 1'b0, rst = 1'b1;
  logic [3:0] op = '0, br_sel = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [7:0] res;
  logic       wr_en, flag_z, flag_c, flag_n, flag_v, br_taken;

  int checks = 0, errors = 0;
  int mz = 0, mc = 0, mn = 0, mv = 0;

  always #10 clk = ~clk;

  alu8_flags i_alu8_flags (
    .clk(clk), .rst(rst), .op(op), .opa(opa), .opb(opb), .br_sel(br_sel),
    .res(res), .wr_en(wr_en), .flag_z(flag_z), .flag_c(flag_c),
    .flag_n(flag_n), .flag_v(flag_v), .br_taken(br_taken)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (op %0d a %0h b %0h)", req, act, exp, op, opa, opb);
    end
  endtask

  function automatic string op_tag(input int o);
    case (o)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic int br_model(input int s);
    case (s)
      0: return mz;
      1: return 1 - mz;
      2: return mc;
      3: return 1 - mc;
      4: return mv;
      5: return 1 - mv;
      6: return mn;
      7: return 1 - mn;
      8: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic step(input int o, input int a, input int b, input int bs, input int r);
    int s, t, er, ec, ev, ewr;
    bit arith;
    @(negedge clk);
    rst = r[0]; op = o[3:0]; opa = a[7:0]; opb = b[7:0]; br_sel = bs[3:0];
    #2;
    arith = (o >= 1 && o <= 5);
    er = 0; ec = 0; ev = 0;
    case (o)
      0: er = b;
      1, 2: begin
        s = a + b + ((o == 2) ? mc : 0);
        er = s % 256; ec = (s > 255);
        ev = ((a ^ er) & (b ^ er) & 128) != 0;
      end
      3, 4, 5: begin
        t = b + ((o == 4) ? (1 - mc) : 0);
        s = a - t;
        er = (s + 512) % 256; ec = (a >= t);
        ev = ((a ^ b) & (a ^ er) & 128) != 0;
      end
      default: ;
    endcase
    ewr = (o <= 4);
    chk(op_tag(o), wr_en, ewr);
    if (ewr) chk(op_tag(o), res, er);
    chk("R10", br_taken, br_model(bs));
    @(posedge clk);
    #2;
    if (r) begin
      mz = 0; mc = 0; mn = 0; mv = 0;
    end else if (arith) begin
      mz = (er == 0); mc = ec; mn = (er >= 128); mv = ev;
    end
    chk(r ? "R9" : (arith ? "R6" : "R8"), flag_z, mz);
    chk(r ? "R9" : (arith ? op_tag(o) : "R8"), flag_c, mc);
    chk(r ? "R9" : (arith ? "R6" : "R8"), flag_n, mn);
    chk(r ? "R9" : (arith ? "R7" : "R8"), flag_v, mv);
  endtask

  initial begin
    int corner [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    chk("R9", {flag_z, flag_c, flag_n, flag_v}, 0);
    for (int i = 0; i < 16; i++) step(5, 8'h40, 8'h40, i, 0);
    for (int i = 0; i < 16; i++) step(3, 8'h10, 8'h90, i, 0);
    for (int o = 0; o < 16; o++)
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          for (int ci = 0; ci < 2; ci++) begin
            step(3, 0, ci ? 0 : 1, 2 + ci, 0);
            step(o, corner[x], corner[y], 2, 0);
          end
    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 15), (k % 997 == 500) ? 1 : 0);
    step(3, 0, 1, 3, 1);
    chk("R9", {flag_z, flag_c, flag_n, flag_v}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule